// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one self-contained DMA channel. Software programs it through four word registers: a control word, a remaining-unit count, a peripheral base address and a memory base address. Once enabled, the channel moves data units one at a time over a single-beat bus master port. Each unit is one read from the source side followed by one write to the destination side. The direction bit selects whether the peripheral or the memory address is the source.

A unit normally starts on a request from the attached peripheral, which gets a one-cycle acknowledge when the unit completes. In memory-to-memory mode the channel starts units back to back with no request. The channel reports three single-cycle events: half-way, complete and bus error. A single interrupt line combines the events that are enabled in the control word.

When the count runs out, a normal-mode channel stops with the count at zero. A circular-mode channel restores the programmed count and both base addresses and keeps going.

Top module: `dma_channel_engine`

## Requirements
- R1: Synchronous reset clears all four registers to zero and leaves `bus_valid`, the three event outputs and `irq` low. The all-zero control word means: disabled, peripheral is the source, no increments, byte units on both sides, normal mode, lowest priority, memory-to-memory off.
- R2: Register offsets on `reg_addr` are 0 control, 1 count, 2 peripheral base and 3 memory base. The control bits are:
  - bit 0: enable
  - bits 1, 2, 3: complete, half-way and error interrupt enables
  - bit 4: direction (1 means memory is the source)
  - bit 5: circular mode
  - bit 6: peripheral increment
  - bit 7: memory increment
  - bits 9:8: peripheral unit size
  - bits 11:10: memory unit size
  - bits 13:12: priority
  - bit 14: memory-to-memory
  The control and base registers read back as written. Count reads return the live remaining count.
- R3: A write to the count register while the enable bit is set has no effect.
- R4: A unit is one bus read of the source followed by one bus write of the same data to the destination. Each beat uses the unit size of its own side on `bus_size`. `bus_valid`, `bus_addr` and `bus_write` are held until `bus_ready`.
- R5: Unit size codes are 00 byte, 01 halfword and 10 word. After each unit, an address whose increment bit is set advances by 1, 2 or 4 according to its own side's size; an address with its increment bit clear stays fixed. Both working addresses load from the base registers when the enable bit rises.
- R6: The count drops by one after each completed unit. With memory-to-memory off, a unit starts only when `periph_req` is sampled high, and each finished unit gives one `periph_ack` pulse. With memory-to-memory on, units run back to back.
- R7: In normal mode, the unit that brings the count to zero pulses `evt_tc`, and no further unit starts.
- R8: In circular mode, the final unit pulses `evt_tc`, the count reloads to the programmed value, both addresses return to their bases, and transfers continue.
- R9: `evt_ht` pulses once per pass, on the unit after which the count equals the programmed count shifted right by one.
- R10: An error response on either beat pulses `evt_te`, clears the enable bit, abandons the unit and leaves the count unchanged.
- R11: With a count of zero, the channel starts no bus beat even when enabled.
- R12: `irq` is high in exactly the cycles where an event pulse is high and that event's interrupt enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| periph_req | input | 1 | Peripheral request for one unit |
| periph_ack | output | 1 | One-cycle pulse when a requested unit finishes |
| bus_valid | output | 1 | Bus beat request |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | 32 | Beat byte address |
| bus_size | output | 2 | Beat unit size code |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Beat accepted |
| bus_rdata | input | 32 | Read data |
| bus_err | input | 1 | Error response, valid with bus_ready |
| evt_tc | output | 1 | Transfer-complete pulse |
| evt_ht | output | 1 | Half-way pulse |
| evt_te | output | 1 | Bus-error pulse |
| irq | output | 1 | Enabled events combined |

## Verification
A count that goes wrong shows at the count register read one cycle after the write beat of the affected unit. A few units later it also shows as a missing, early or extra complete or half-way pulse, or as a wrong number of write beats. A working address that goes wrong shows at once on `bus_addr` of the next beat, so the bench records the last read and write addresses and compares them with the values worked out from base, step and count. A stale enable bit after an error, or a count that was overwritten while the channel was enabled, shows on the next control or count read.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int CTRL_W = 15;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_PBASE = 2'd2;
    localparam logic [1:0] REG_MBASE = 2'd3;

    typedef enum logic [1:0] {
        UNIT_BYTE = 2'b00,
        UNIT_HALF = 2'b01,
        UNIT_WORD = 2'b10,
        UNIT_RSVD = 2'b11
    } unit_e;

    // Packed from MSB to LSB; en lands on bit 0.
    typedef struct packed {
        logic       m2m;
        logic [1:0] prio;
        unit_e      msize;
        unit_e      psize;
        logic       minc;
        logic       pinc;
        logic       circ;
        logic       dir;
        logic       te_ie;
        logic       ht_ie;
        logic       tc_ie;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_st_e;

    // Byte step for one unit; the reserved code behaves as a word.
    function automatic logic [2:0] unit_step(unit_e u);
        case (u)
            UNIT_BYTE: return 3'd1;
            UNIT_HALF: return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             unit_done,
    input  logic             abort,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] prog_q,
    output logic [REG_W-1:0] pbase_q,
    output logic [REG_W-1:0] mbase_q
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_after;

    always_comb begin
        if (cnt_q == CNT_ONE)
            cnt_after = ctrl_q.circ ? prog_q : '0;
        else
            cnt_after = cnt_q - CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cnt_q   <= '0;
            prog_q  <= '0;
            pbase_q <= '0;
            mbase_q <= '0;
        end else begin
            if (reg_we && reg_addr == REG_CTRL)
                ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            // A bus error overrides any enable written in the same cycle.
            if (abort)
                ctrl_q.en <= 1'b0;
            // A finishing unit wins over a count write in the same cycle.
            if (unit_done) begin
                cnt_q <= cnt_after;
            end else if (reg_we && reg_addr == REG_COUNT && !ctrl_q.en) begin
                cnt_q  <= reg_wdata[CNT_W-1:0];
                prog_q <= reg_wdata[CNT_W-1:0];
            end
            if (reg_we && reg_addr == REG_PBASE)
                pbase_q <= reg_wdata;
            if (reg_we && reg_addr == REG_MBASE)
                mbase_q <= reg_wdata;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL:  reg_rdata = REG_W'(ctrl_q);
            REG_COUNT: reg_rdata = REG_W'(cnt_q);
            REG_PBASE: reg_rdata = pbase_q;
            default:   reg_rdata = mbase_q;
        endcase
    end

endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  prog_q,
    input  logic [ADDR_W-1:0] pbase,
    input  logic [ADDR_W-1:0] mbase,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic              unit_done,
    output logic              abort,
    output logic              evt_tc,
    output logic              evt_ht,
    output logic              evt_te
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    xfer_st_e          st;
    logic [ADDR_W-1:0] pcur, mcur;
    logic [DATA_W-1:0] data_q;
    logic              en_d;
    logic              start, hs, last_unit, half_unit, en_rise;
    logic              unused_ctrl;

    assign unused_ctrl = ^{ctrl.prio, ctrl.tc_ie, ctrl.ht_ie, ctrl.te_ie};

    assign en_rise   = ctrl.en && !en_d;
    assign start     = (st == ST_IDLE) && ctrl.en && (cnt_q != '0)
                       && (ctrl.m2m || periph_req);
    assign hs        = bus_valid && bus_ready;
    assign unit_done = (st == ST_WRITE) && hs && !bus_err;
    assign abort     = hs && bus_err;
    assign last_unit = (cnt_q == CNT_ONE);
    assign half_unit = ((cnt_q - CNT_ONE) == (prog_q >> 1));

    always_comb begin
        bus_valid = (st != ST_IDLE);
        bus_write = (st == ST_WRITE);
        bus_wdata = data_q;
        // The source side is read and the other side is written.
        if ((st == ST_READ) == ctrl.dir) begin
            bus_addr = mcur;
            bus_size = ctrl.msize;
        end else begin
            bus_addr = pcur;
            bus_size = ctrl.psize;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            pcur       <= '0;
            mcur       <= '0;
            data_q     <= '0;
            en_d       <= 1'b0;
            evt_tc     <= 1'b0;
            evt_ht     <= 1'b0;
            evt_te     <= 1'b0;
            periph_ack <= 1'b0;
        end else begin
            en_d       <= ctrl.en;
            evt_tc     <= 1'b0;
            evt_ht     <= 1'b0;
            evt_te     <= 1'b0;
            periph_ack <= 1'b0;
            if (en_rise) begin
                pcur <= pbase;
                mcur <= mbase;
            end
            case (st)
                ST_IDLE: if (start) st <= ST_READ;
                ST_READ: if (hs) begin
                    if (bus_err) begin
                        evt_te <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        data_q <= bus_rdata;
                        st     <= ST_WRITE;
                    end
                end
                ST_WRITE: if (hs) begin
                    st <= ST_IDLE;
                    if (bus_err) begin
                        evt_te <= 1'b1;
                    end else begin
                        evt_tc     <= last_unit;
                        evt_ht     <= half_unit;
                        periph_ack <= !ctrl.m2m;
                        if (last_unit && ctrl.circ) begin
                            pcur <= pbase;
                            mcur <= mbase;
                        end else begin
                            if (ctrl.pinc) pcur <= pcur + ADDR_W'(unit_step(ctrl.psize));
                            if (ctrl.minc) mcur <= mcur + ADDR_W'(unit_step(ctrl.msize));
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_channel_engine.sv
module dma_channel_engine
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic              evt_tc,
    output logic              evt_ht,
    output logic              evt_te,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [CNT_W-1:0]  cnt_q, prog_q;
    logic [ADDR_W-1:0] pbase, mbase;
    logic              unit_done, abort;

    dmach_regs #(.REG_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .unit_done (unit_done),
        .abort     (abort),
        .ctrl_q    (ctrl),
        .cnt_q     (cnt_q),
        .prog_q    (prog_q),
        .pbase_q   (pbase),
        .mbase_q   (mbase)
    );

    dmach_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .cnt_q      (cnt_q),
        .prog_q     (prog_q),
        .pbase      (pbase),
        .mbase      (mbase),
        .periph_req (periph_req),
        .periph_ack (periph_ack),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_ready  (bus_ready),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .unit_done  (unit_done),
        .abort      (abort),
        .evt_tc     (evt_tc),
        .evt_ht     (evt_ht),
        .evt_te     (evt_te)
    );

    assign irq = (evt_tc && ctrl.tc_ie) || (evt_ht && ctrl.ht_ie) || (evt_te && ctrl.te_ie);

endmodule

// File: rtl/dmach_checker.sv
module dmach_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              evt_tc,
    input logic              evt_ht,
    input logic              evt_te,
    input logic              periph_ack,
    input logic              en,
    input logic              circ,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  prog
);

    // R4: an unaccepted beat stays put
    assert_hold_beat_R4: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    // R6: acknowledge only follows a clean write beat
    assert_ack_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        periph_ack |-> $past(bus_valid && bus_write && bus_ready && !bus_err));

    // R7: normal completion leaves zero
    assert_normal_zero_R7: assert property (@(posedge clk) disable iff (rst)
        evt_tc && !circ |-> cnt == '0);

    // R8: circular completion restores the programmed count
    assert_circ_reload_R8: assert property (@(posedge clk) disable iff (rst)
        evt_tc && circ |-> cnt == prog);

    // R9: half-way point
    assert_half_point_R9: assert property (@(posedge clk) disable iff (rst)
        evt_ht && !evt_tc |-> cnt == (prog >> 1));

    // R10: error disables and excludes the other events
    assert_error_disables_R10: assert property (@(posedge clk) disable iff (rst)
        evt_te |-> !en && !evt_tc && !evt_ht);

    // R11: empty count never issues a beat
    assert_zero_idle_R11: assert property (@(posedge clk) disable iff (rst)
        cnt == '0 && !bus_valid |=> !bus_valid);

endmodule

bind dma_channel_engine dmach_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_write  (bus_write),
    .bus_err    (bus_err),
    .bus_addr   (bus_addr),
    .evt_tc     (evt_tc),
    .evt_ht     (evt_ht),
    .evt_te     (evt_te),
    .periph_ack (periph_ack),
    .en         (ctrl.en),
    .circ       (ctrl.circ),
    .cnt        (cnt_q),
    .prog       (prog_q)
);

// File: tb/dma_channel_engine_bench.sv
module dma_channel_engine_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic        bus_valid, bus_write;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        bus_ready, bus_err;
    logic        evt_tc, evt_ht, evt_te, irq;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic        clr_mon = 1'b0;
    logic        done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_channel_engine u_dma_channel_engine (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .evt_tc(evt_tc), .evt_ht(evt_ht), .evt_te(evt_te), .irq(irq)
    );

    // Byte memory, always ready, little-endian, optional error address
    logic [7:0] mem [256];
    assign bus_ready = bus_valid;
    assign bus_err   = bus_valid && err_en && (bus_addr == err_addr);

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < 4; i++)
            if (i < nbytes(bus_size))
                bus_rdata[8*i +: 8] = mem[8'(bus_addr[7:0] + 8'(i))];
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (bus_valid && bus_write && !bus_err) begin
            for (int i = 0; i < 4; i++)
                if (i < nbytes(bus_size))
                    mem[8'(bus_addr[7:0] + 8'(i))] <= bus_wdata[8*i +: 8];
        end
    end

    // Port monitor
    int n_wr, n_tc, n_ht, n_te, n_ack, n_irq, n_valid;
    logic [31:0] last_rd, last_wr, ht_cnt;
    always @(posedge clk) begin
        if (clr_mon) begin
            n_wr = 0; n_tc = 0; n_ht = 0; n_te = 0; n_ack = 0; n_irq = 0; n_valid = 0;
            last_rd = '1; last_wr = '1; ht_cnt = '1;
        end else begin
            if (bus_valid) n_valid++;
            if (bus_valid && bus_ready && !bus_err) begin
                if (bus_write) begin n_wr++; last_wr = bus_addr; end
                else last_rd = bus_addr;
            end
            if (evt_tc) n_tc++;
            if (evt_ht) begin n_ht++; if (reg_addr == 2'd1) ht_cnt = reg_rdata; end
            if (evt_te) n_te++;
            if (periph_ack) n_ack++;
            if (irq) n_irq++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 2'd1;
    endtask

    task automatic clear_mon();
        @(negedge clk); clr_mon = 1'b1;
        @(negedge clk); clr_mon = 1'b0;
    endtask

    task automatic req_pulse();
        @(negedge clk); periph_req = 1'b1;
        @(negedge clk); periph_req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // ctrl (enable off), count, expected last read address, last write address
    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] cnt;
        logic [7:0]  rd;
        logic [7:0]  wr;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{16'h40C0, 16'd4, 8'h13, 8'h83},   // byte to byte, both increment
        '{16'h4980, 16'd3, 8'h10, 8'h88},   // fixed half source, word destination
        '{16'h46D0, 16'd2, 8'h82, 8'h14},   // memory source half, peripheral word
        '{16'h7240, 16'd5, 8'h20, 8'h80}    // word source increments, fixed destination
    };

    logic [31:0] v;

    initial begin
        clr_mon = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; clr_mon = 1'b0;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rreg(2'(a), v); chk("R1 register zero after reset", v, 32'h0);
        end
        chk("R1 idle bus and events", {28'h0, bus_valid, evt_tc, evt_ht, irq}, 32'h0);

        // R2: control layout round trip, base registers
        wreg(2'd0, 32'h7FFE); rreg(2'd0, v); chk("R2 control readback", v, 32'h7FFE);
        wreg(2'd0, 32'h0);
        wreg(2'd2, 32'h10); wreg(2'd3, 32'h80);
        rreg(2'd2, v); chk("R2 peripheral base readback", v, 32'h10);
        rreg(2'd3, v); chk("R2 memory base readback", v, 32'h80);

        // Table of memory-to-memory runs: R4 R5 R6 R7 R9
        for (int i = 0; i < 4; i++) begin
            wreg(2'd0, 32'h0);
            clear_mon();
            wreg(2'd1, 32'(VECS[i].cnt));
            wreg(2'd0, 32'(VECS[i].ctrl) | 32'h1);
            repeat (int'(VECS[i].cnt) * 3 + 10) @(negedge clk);
            chk("R6 write beats equal count", 32'(n_wr), 32'(VECS[i].cnt));
            chk("R5 last read address", last_rd, 32'(VECS[i].rd));
            chk("R5 last write address", last_wr, 32'(VECS[i].wr));
            rreg(2'd1, v); chk("R7 count stops at zero", v, 32'h0);
            chk("R7 one complete pulse", 32'(n_tc), 32'd1);
            chk("R9 one half pulse", 32'(n_ht), 32'd1);
            chk("R9 count at half pulse", ht_cnt, 32'(VECS[i].cnt >> 1));
            if (i == 0)
                for (int b = 0; b < 4; b++)
                    chk("R4 copied byte", 32'(mem[8'h80 + b]), 32'(mem[8'h10 + b]));
        end

        // Peripheral-request mode: R6 R3 R7 R12
        wreg(2'd0, 32'h0);
        clear_mon();
        wreg(2'd1, 32'd2);
        wreg(2'd0, 32'h00C1);
        repeat (10) @(negedge clk);
        chk("R6 no unit without request", 32'(n_wr), 32'd0);
        req_pulse();
        chk("R6 one unit per request", 32'(n_wr), 32'd1);
        chk("R6 one acknowledge", 32'(n_ack), 32'd1);
        rreg(2'd1, v); chk("R6 count decremented", v, 32'd1);
        wreg(2'd1, 32'd9);
        rreg(2'd1, v); chk("R3 count write ignored while enabled", v, 32'd1);
        req_pulse();
        chk("R7 complete pulse", 32'(n_tc), 32'd1);
        chk("R12 no irq with complete disabled", 32'(n_irq), 32'd0);
        req_pulse();
        chk("R7 no unit after zero", 32'(n_wr), 32'd2);

        // Circular: R8 R12
        wreg(2'd0, 32'h0);
        clear_mon();
        wreg(2'd1, 32'd2);
        wreg(2'd0, 32'h00E3);
        req_pulse(); req_pulse();
        rreg(2'd1, v); chk("R8 count reloaded", v, 32'd2);
        chk("R8 complete pulse", 32'(n_tc), 32'd1);
        chk("R12 irq on enabled complete", 32'(n_irq), 32'd1);
        chk("R8 second write address", last_wr, 32'h81);
        req_pulse();
        chk("R8 address back at base", last_wr, 32'h80);
        rreg(2'd1, v); chk("R8 transfers continue", v, 32'd1);

        // Bus error: R10 R12
        wreg(2'd0, 32'h0);
        clear_mon();
        err_addr = 32'h81; err_en = 1'b1;
        wreg(2'd1, 32'd4);
        wreg(2'd0, 32'h40C9);
        repeat (20) @(negedge clk);
        chk("R10 one error pulse", 32'(n_te), 32'd1);
        rreg(2'd0, v); chk("R10 enable cleared", v, 32'h40C8);
        rreg(2'd1, v); chk("R10 count not decremented", v, 32'd3);
        chk("R10 one good write", 32'(n_wr), 32'd1);
        chk("R10 no complete", 32'(n_tc), 32'd0);
        chk("R12 irq on enabled error", 32'(n_irq), 32'd1);
        err_en = 1'b0;

        // Zero count: R11
        wreg(2'd0, 32'h0);
        wreg(2'd1, 32'd0);
        clear_mon();
        wreg(2'd0, 32'h4001);
        repeat (10) @(negedge clk);
        chk("R11 no beat with zero count", 32'(n_valid), 32'd0);

        // Reset while running: R1
        wreg(2'd0, 32'h0);
        wreg(2'd1, 32'd5);
        wreg(2'd0, 32'h40C1);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1 chk("R1 bus idle after reset", {31'h0, bus_valid}, 32'h0);
        for (int a = 0; a < 4; a++) begin
            rreg(2'd0 + 2'(a), v); chk("R1 register zero after mid-run reset", v, 32'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

endmodule